// File: doc/BRIEF.md
# Bidirectional GPIO Port with Toggle Writes

This block is an eight-pin (parameterised) general-purpose I/O port hung off a plain CPU register bus. Software sees three registers: an output-level register, a drive-enable register and a read-only view of the pad levels. The pad levels pass through a synchroniser before software can read them. Writing to the read-only pad view is not lost. Each one bit in the written word inverts the matching bit of the output-level register, so a single bus write can flip any group of pins.

Each pin gives the pad an output level, an output enable and a weak pull-up enable. A pin that is not driven and whose output-level bit is one gets its pull-up, unless the global pull-up kill input is high. A peripheral can take over the drive enable and level of a single pin through a per-pin override. The override does not alter the stored registers, and the other pins are not affected.

Top module: `gpio_toggle_port`

## Requirements
- R1: After reset the output-level register and the drive-enable register are both zero. pad_oe, pad_out and pad_pu are then all zero.
- R2: The bus addresses are 0 for the output-level register and 1 for the drive-enable register. Both can be written and read back. Address 3 reads as zero, and writes to it change nothing.
- R3: A write to address 2 inverts each output-level bit whose written bit is one. Bits written as zero keep their value.
- R4: A write to address 2 never changes the drive-enable register. A read of address 2 returns the synchronised pad levels.
- R5: When a pin's override is inactive, pad_oe equals its drive-enable bit and pad_out equals its output-level bit.
- R6: When pull-up kill is low, a pin's pad_pu is one exactly when the pin is not driven and its level bit is one.
- R7: When pullup_disable is high, every pad_pu bit is zero.
- R8: A change on pad_in appears at address 2 after exactly two rising clock edges, and not after one.
- R9: When alt_en[i] is high, pad_oe[i] follows alt_dir[i] and pad_out[i] follows alt_val[i]. The stored registers and all other pins are unaffected.
- R10: For an overridden pin, the pull-up rule of R6 and R7 uses the override direction and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| pullup_disable | input | 1 | Global pull-up kill |
| alt_en | input | 8 | Per-pin override enable |
| alt_dir | input | 8 | Override drive enable |
| alt_val | input | 8 | Override output level |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The bench provokes two overlaps. In the first, a toggle write lands on a pin whose override is active. The check is that pad_out keeps following the override while the output-level register reads back inverted, and that releasing the override exposes the toggled level. In the second, a pad change arrives in the same cycle as a toggle write to address 2. The synchroniser's two-edge delay must hold regardless of the write. Expected values are computed arithmetically from the requirement formulas across sweeps of level, direction and pull-up kill.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_LEVEL = 2'd0,
    REG_DRIVE = 2'd1,
    REG_PADS  = 2'd2,
    REG_NONE  = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] level_q,
  output logic [N-1:0] drive_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      drive_q <= '0;
    end else if (wr) begin
      case (gpio_addr_e'(addr))
        REG_LEVEL: level_q <= wdata;
        REG_DRIVE: drive_q <= wdata;
        REG_PADS:  level_q <= level_q ^ wdata;
        default:   ;
      endcase
    end
  end

  // R3: a write to the pad view flips exactly the bits written as one
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_PADS) |=> (level_q == ($past(level_q) ^ $past(wdata))));

  // R4: a write to the pad view leaves the drive-enable register alone
  assert_pads_keep_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_PADS) |=> $stable(drive_q));

  // R2: with no write strobe, both registers hold
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(level_q) && $stable(drive_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lat_chk
      logic [1:0] since_rst;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
      // R8: the pad view equals the pad level from two edges earlier
      assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic level,
  input  logic drive,
  input  logic pud,
  input  logic ov_en,
  input  logic ov_dir,
  input  logic ov_val,
  output logic out,
  output logic oe,
  output logic pu
);
  logic eff_dir, eff_val;

  always_comb begin
    eff_dir = ov_en ? ov_dir : drive;
    eff_val = ov_en ? ov_val : level;
    out     = eff_val;
    oe      = eff_dir;
    pu      = !eff_dir && eff_val && !pud;
  end
endmodule

// File: rtl/gpio_toggle_port.sv
module gpio_toggle_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic                pullup_disable,
  input  logic [NUM_PINS-1:0] alt_en,
  input  logic [NUM_PINS-1:0] alt_dir,
  input  logic [NUM_PINS-1:0] alt_val,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu
);
  logic [NUM_PINS-1:0] level_q, drive_q, pads_sync;

  gpio_regs #(.N(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .level_q(level_q), .drive_q(drive_q)
  );

  gpio_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pads_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_cell u_cell (
      .level(level_q[i]), .drive(drive_q[i]), .pud(pullup_disable),
      .ov_en(alt_en[i]), .ov_dir(alt_dir[i]), .ov_val(alt_val[i]),
      .out(pad_out[i]), .oe(pad_oe[i]), .pu(pad_pu[i])
    );
  end

  always_comb begin
    case (gpio_addr_e'(bus_addr))
      REG_LEVEL: bus_rdata = level_q;
      REG_DRIVE: bus_rdata = drive_q;
      REG_PADS:  bus_rdata = pads_sync;
      default:   bus_rdata = '0;
    endcase
  end

  // R7: the global kill silences every pull-up
  assert_pud_kills_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_disable |-> (pad_pu == '0));

  // R6: a driven pin never also has its pull-up on
  assert_no_pull_when_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_pu) == '0));

  // R9: non-overridden pins follow the stored registers
  assert_plain_pins_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ drive_q) & ~alt_en) == '0));
endmodule

// File: tb/tb_gpio_toggle_port.sv
`timescale 1ns/100ps
module tb_gpio_toggle_port;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [N-1:0] bus_wdata = 0, bus_rdata;
  logic pullup_disable = 0;
  logic [N-1:0] alt_en = 0, alt_dir = 0, alt_val = 0, pad_in = 0;
  logic [N-1:0] pad_out, pad_oe, pad_pu;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_toggle_port dut (.*);

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] r, lvl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r); chk("R1 level", r, 0);
    rd(1, r); chk("R1 drive", r, 0);
    chk("R1 pad_oe", pad_oe, 0); chk("R1 pad_out", pad_out, 0); chk("R1 pad_pu", pad_pu, 0);

    // R2 / R5 full sweep of level and drive writes
    for (int v = 0; v < 256; v++) begin
      wr(0, v[N-1:0]); wr(1, ~v[N-1:0]);
      rd(0, r); chk("R2 level rb", r, v[N-1:0]);
      rd(1, r); chk("R2 drive rb", r, ~v[N-1:0]);
      chk("R5 pad_out", pad_out, v[N-1:0]);
      chk("R5 pad_oe", pad_oe, ~v[N-1:0]);
    end
    // R2 address 3
    wr(0, 8'h3C); wr(1, 8'hA5); wr(3, 8'hFF);
    rd(3, r); chk("R2 addr3 reads zero", r, 0);
    rd(0, r); chk("R2 addr3 write ignored level", r, 8'h3C);
    rd(1, r); chk("R2 addr3 write ignored drive", r, 8'hA5);

    // R3 / R4 toggle sweep
    lvl = 8'h3C;
    for (int m = 0; m < 256; m += 7) begin
      wr(2, m[N-1:0]); lvl = lvl ^ m[N-1:0];
      rd(0, r); chk("R3 toggle", r, lvl);
      rd(1, r); chk("R4 drive untouched", r, 8'hA5);
    end
    wr(0, 8'h5A); wr(2, 8'h00);
    rd(0, r); chk("R3 zero mask keeps", r, 8'h5A);

    // R6 / R7 pull-up sweep
    for (int d = 0; d < 256; d += 5) begin
      for (int l = 0; l < 256; l += 51) begin
        for (int k = 0; k < 2; k++) begin
          wr(1, d[N-1:0]); wr(0, l[N-1:0]);
          pullup_disable = k[0]; #0.5;
          if (k == 0) chk("R6 pull-up", pad_pu, ~d[N-1:0] & l[N-1:0]);
          else        chk("R7 pud", pad_pu, 0);
        end
      end
    end
    pullup_disable = 0;

    // R8 latency, with a same-cycle toggle write to the pad view
    for (int p = 1; p < 256; p += 37) begin
      @(negedge clk); pad_in = p[N-1:0];
      bus_addr = 2; bus_wdata = 8'hFF; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
      rd(2, r); chk("R8 not after one edge", r, (p == 1) ? 8'h00 : (p - 37));
      @(negedge clk);
      rd(2, r); chk("R8 after two edges", r, p[N-1:0]);
    end

    // R9 / R10 override, overlapping with a toggle write
    wr(0, 8'h00); wr(1, 8'h00);
    alt_en = 8'h01; alt_dir = 8'h01; alt_val = 8'h00;
    wr(2, 8'h03);
    rd(0, r); chk("R9 register toggled under override", r, 8'h03);
    chk("R9 pad_out override", pad_out, 8'h02);
    chk("R9 pad_oe override", pad_oe, 8'h01);
    chk("R10 driven override no pull", pad_pu, 8'h02);
    alt_dir = 8'h00; alt_val = 8'h01; #0.5;
    chk("R10 override pull", pad_pu, 8'h03);
    pullup_disable = 1; #0.5;
    chk("R10 override pud", pad_pu, 8'h00);
    pullup_disable = 0;
    rd(1, r); chk("R9 drive untouched", r, 8'h00);
    alt_en = 8'h00; alt_val = 8'h00; #0.5;
    chk("R9 release shows toggled level", pad_out, 8'h03);

    finish_run();
  end
endmodule